// File: doc/BRIEF.md
# Packed-SIMD extension instruction length decoder

This block inspects a window of instruction bytes and decides whether they open one of the supplemental packed-integer SIMD instructions that use the two-byte escape after 0x0F. If they do, it reports the instruction's full byte length and its decoded fields. Those fields are the operand width, opcode, destination and source register numbers including their upper-bank bits, the ModRM mode, the sign-extended displacement, and the byte-align immediate. A trap handler or a software emulation assist would use it to learn how far to advance past a faulting instruction and which registers it names.

A window is offered with `in_valid`, together with the number of bytes in it that are meaningful. The decoded result appears on registered outputs one clock later, marked by `out_valid`, and stays there until the next window arrives. Encodings outside the supported set are reported as unhandled and consume zero bytes. A supported encoding that runs past the meaningful bytes is reported as truncated.

Top module: `simd_ext_len_decoder`

## Requirements
- R1: A 0x66 in window byte 0 selects 128-bit operation (`out_wide`=1), and every later field is found one byte further on. Without it, `out_wide`=0.
- R2: A byte whose upper nibble is 0x4, placed right after the optional 0x66, is an extension prefix. Its bit 0 becomes bit 3 of `out_src` and its bit 2 becomes bit 3 of `out_dst`. Without it, both of those bits are 0.
- R3: If the byte after the optional prefixes is not 0x0F, the window is unhandled. An unhandled window gives `out_handled`=0, `out_truncated`=0, `out_len`=0, and every field output 0.
- R4: Escape 0x38 is accepted with opcodes 0x00–0x0B and 0x1C–0x1E. Escape 0x3A is accepted only with opcode 0x0F (the byte-align operation). Every other escape/opcode pair, including 0x38 with 0x0F, is unhandled.
- R5: `out_mode` carries ModRM bits 7:6. Mode 1 adds one displacement byte, mode 2 adds four, and modes 0 and 3 add none.
- R6: `out_disp` is the displacement sign-extended to 32 bits, with the four-byte form read little-endian. It is 0 when there is no displacement.
- R7: For the byte-align operation, `out_imm` is the byte right after the displacement (or right after ModRM if there is none), and `out_has_imm`=1. For every other operation both are 0.
- R8: `out_dst` bits 2:0 are ModRM bits 5:3, and `out_src` bits 2:0 are ModRM bits 2:0.
- R9: `out_len` is the sum of the optional 0x66, the optional extension prefix, 0x0F, the escape byte, the opcode, ModRM, the displacement bytes and the align immediate. This gives a value from 4 to 11.
- R10: A supported instruction whose length exceeds `in_count` gives `out_truncated`=1, `out_handled`=0, `out_len`=0, and all fields 0. A length equal to `in_count` decodes normally.
- R11: `out_valid` is high exactly in the cycle after each `in_valid` cycle. All outputs hold while `in_valid` is low. A synchronous reset drives `out_valid` and every output to 0, and reset takes priority over `in_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Window strobe |
| in_bytes | input | 8*WINDOW | Window, byte i in bits 8i+7:8i |
| in_count | input | clog2(WINDOW+1) | Number of meaningful bytes in the window |
| out_valid | output | 1 | Result strobe, one cycle after in_valid |
| out_handled | output | 1 | Supported and complete instruction |
| out_truncated | output | 1 | Supported, but longer than in_count |
| out_len | output | clog2(WINDOW+1) | Consumed byte count |
| out_wide | output | 1 | 128-bit operation |
| out_opcode | output | 8 | Opcode byte |
| out_dst | output | 4 | Destination register with upper-bank bit |
| out_src | output | 4 | Source/base register with upper-bank bit |
| out_mode | output | 2 | ModRM mode bits |
| out_disp | output | 32 | Sign-extended displacement |
| out_imm | output | 8 | Align immediate |
| out_has_imm | output | 1 | Immediate present |

## Verification
The assertions check the following on every cycle:
- the strobe timing and the holding of outputs between strobes;
- that handled and truncated never appear together;
- that a non-decoded result always reports zero length;
- that a handled length stays within 4 to 11 bytes;
- that the immediate flag appears only with the align opcode;
- that a one-byte displacement is sign-extended.

Only the bench's vectors can show that the correct byte is chosen as displacement or immediate when prefixes shift the layout. The same holds for the exact set of accepted opcodes and the exact boundary where truncation begins.

// File: rtl/simd_ext_len_decoder.sv
module simd_ext_len_decoder #(
  parameter int WINDOW = 16
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         in_valid,
  input  logic [8*WINDOW-1:0]          in_bytes,
  input  logic [$clog2(WINDOW+1)-1:0]  in_count,
  output logic                         out_valid,
  output logic                         out_handled,
  output logic                         out_truncated,
  output logic [$clog2(WINDOW+1)-1:0]  out_len,
  output logic                         out_wide,
  output logic [7:0]                   out_opcode,
  output logic [3:0]                   out_dst,
  output logic [3:0]                   out_src,
  output logic [1:0]                   out_mode,
  output logic [31:0]                  out_disp,
  output logic [7:0]                   out_imm,
  output logic                         out_has_imm
);
  localparam int IW = $clog2(WINDOW);
  localparam int CW = $clog2(WINDOW+1);

  logic [7:0] win [WINDOW];
  for (genvar g = 0; g < WINDOW; g++) begin : g_win
    assign win[g] = in_bytes[8*g +: 8];
  end

  wire          wide   = (win[0] == 8'h66);
  wire [IW-1:0] rx_at  = IW'(wide);
  wire          ext    = (win[rx_at][7:4] == 4'h4);
  wire          src_hi = ext && win[rx_at][0];
  wire          dst_hi = ext && win[rx_at][2];
  wire [IW-1:0] of_at  = rx_at + IW'(ext);
  wire [IW-1:0] esc_at = of_at + IW'(1);
  wire [IW-1:0] op_at  = of_at + IW'(2);
  wire [IW-1:0] mr_at  = of_at + IW'(3);
  wire [IW-1:0] d_at   = of_at + IW'(4);

  wire [7:0] esc   = win[esc_at];
  wire [7:0] opc   = win[op_at];
  wire [7:0] modrm = win[mr_at];

  wire has_0f = (win[of_at] == 8'h0F);
  wire op_38  = (esc == 8'h38) &&
                ((opc <= 8'h0B) || (opc >= 8'h1C && opc <= 8'h1E));
  wire align  = (esc == 8'h3A) && (opc == 8'h0F);
  wire known  = has_0f && (op_38 || align);

  wire [2:0] dlen = (modrm[7:6] == 2'b01) ? 3'd1 :
                    (modrm[7:6] == 2'b10) ? 3'd4 : 3'd0;
  wire [IW-1:0] imm_at = d_at + IW'(dlen);
  wire [CW-1:0] len = CW'(d_at) + CW'(dlen) + CW'(align);
  wire          fits = (len <= in_count);
  wire          ok   = known && fits;

  logic [31:0] disp;
  always_comb begin
    case (dlen)
      3'd1:    disp = {{24{win[d_at][7]}}, win[d_at]};
      3'd4:    disp = {win[d_at + IW'(3)], win[d_at + IW'(2)],
                       win[d_at + IW'(1)], win[d_at]};
      default: disp = 32'd0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid     <= 1'b0;
      out_handled   <= 1'b0;
      out_truncated <= 1'b0;
      out_len       <= '0;
      out_wide      <= 1'b0;
      out_opcode    <= '0;
      out_dst       <= '0;
      out_src       <= '0;
      out_mode      <= '0;
      out_disp      <= '0;
      out_imm       <= '0;
      out_has_imm   <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_handled   <= ok;
        out_truncated <= known && !fits;
        out_len       <= ok ? len : '0;
        out_wide      <= ok && wide;
        out_opcode    <= ok ? opc : 8'h00;
        out_dst       <= ok ? {dst_hi, modrm[5:3]} : 4'h0;
        out_src       <= ok ? {src_hi, modrm[2:0]} : 4'h0;
        out_mode      <= ok ? modrm[7:6] : 2'b00;
        out_disp      <= ok ? disp : 32'd0;
        out_imm       <= (ok && align) ? win[imm_at] : 8'h00;
        out_has_imm   <= ok && align;
      end
    end
  end

  assert_valid_follows_R11: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);
  assert_valid_only_after_strobe_R11: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);
  assert_hold_when_idle_R11: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> ($stable(out_len) && $stable(out_disp) && $stable(out_handled)));
  assert_excl_status_R10: assert property (@(posedge clk) disable iff (rst)
    !(out_handled && out_truncated));
  assert_zero_len_R3: assert property (@(posedge clk) disable iff (rst)
    !out_handled |-> (out_len == '0));
  assert_len_range_R9: assert property (@(posedge clk) disable iff (rst)
    out_handled |-> (out_len >= CW'(4) && out_len <= CW'(11)));
  assert_imm_only_align_R7: assert property (@(posedge clk) disable iff (rst)
    out_has_imm |-> (out_opcode == 8'h0F && out_handled));
  assert_disp8_sext_R6: assert property (@(posedge clk) disable iff (rst)
    (out_handled && out_mode == 2'b01) |->
      (out_disp[31:8] == {24{out_disp[7]}}));
endmodule

// File: tb/simd_ext_len_decoder_tb.sv
`timescale 1ns/1ps
module simd_ext_len_decoder_tb;
  localparam int WINDOW = 16;
  localparam int CW = $clog2(WINDOW+1);

  typedef struct packed {
    logic [87:0] seq;
    logic [4:0]  n;
    logic [4:0]  cnt;
    logic [4:0]  len;
    logic        hnd;
    logic        trc;
    logic        wide;
    logic [7:0]  op;
    logic [3:0]  dst;
    logic [3:0]  src;
    logic [1:0]  mode;
    logic [31:0] disp;
    logic [7:0]  imm;
    logic        himm;
  } vec_t;

  localparam int NV = 24;
  localparam vec_t VEC [NV] = '{
    '{88'h660F380000,           5'd5, 5'd5, 5'd5, 1'b1,1'b0,1'b1, 8'h00,4'h0,4'h0,2'd0,32'h0,8'h00,1'b0},
    '{88'h660F38004001,         5'd6, 5'd6, 5'd6, 1'b1,1'b0,1'b1, 8'h00,4'h0,4'h0,2'd1,32'h1,8'h00,1'b0},
    '{88'h660F38008001020304,   5'd9, 5'd9, 5'd9, 1'b1,1'b0,1'b1, 8'h00,4'h0,4'h0,2'd2,32'h04030201,8'h00,1'b0},
    '{88'h660F3800C0,           5'd5, 5'd5, 5'd5, 1'b1,1'b0,1'b1, 8'h00,4'h0,4'h0,2'd3,32'h0,8'h00,1'b0},
    '{88'h660F3A0F0001,         5'd6, 5'd6, 5'd6, 1'b1,1'b0,1'b1, 8'h0F,4'h0,4'h0,2'd0,32'h0,8'h01,1'b1},
    '{88'h660F3A0F400102,       5'd7, 5'd7, 5'd7, 1'b1,1'b0,1'b1, 8'h0F,4'h0,4'h0,2'd1,32'h1,8'h02,1'b1},
    '{88'h660F3A0F800102030405, 5'd10,5'd10,5'd10,1'b1,1'b0,1'b1, 8'h0F,4'h0,4'h0,2'd2,32'h04030201,8'h05,1'b1},
    '{88'h660F3A0FFF01,         5'd6, 5'd6, 5'd6, 1'b1,1'b0,1'b1, 8'h0F,4'h7,4'h7,2'd3,32'h0,8'h01,1'b1},
    '{88'h0F380B48F0,           5'd5, 5'd5, 5'd5, 1'b1,1'b0,1'b0, 8'h0B,4'h1,4'h0,2'd1,32'hFFFFFFF0,8'h00,1'b0},
    '{88'h0F3A0F85FEFFFFFF07,   5'd9, 5'd9, 5'd9, 1'b1,1'b0,1'b0, 8'h0F,4'h0,4'h5,2'd2,32'hFFFFFFFE,8'h07,1'b1},
    '{88'h66450F381CD3,         5'd6, 5'd6, 5'd6, 1'b1,1'b0,1'b1, 8'h1C,4'hA,4'hB,2'd3,32'h0,8'h00,1'b0},
    '{88'h410F381E08,           5'd5, 5'd5, 5'd5, 1'b1,1'b0,1'b0, 8'h1E,4'h1,4'h8,2'd0,32'h0,8'h00,1'b0},
    '{88'h66440F3A0F7A8003,     5'd8, 5'd8, 5'd8, 1'b1,1'b0,1'b1, 8'h0F,4'hF,4'h2,2'd1,32'hFFFFFF80,8'h03,1'b1},
    '{88'h664C0F3A0F8C78563412FF,5'd11,5'd11,5'd11,1'b1,1'b0,1'b1,8'h0F,4'h9,4'h4,2'd2,32'h12345678,8'hFF,1'b1},
    '{88'h660F380FC0,           5'd5, 5'd5, 5'd0, 1'b0,1'b0,1'b0, 8'h00,4'h0,4'h0,2'd0,32'h0,8'h00,1'b0},
    '{88'h660F3A0EC000,         5'd6, 5'd6, 5'd0, 1'b0,1'b0,1'b0, 8'h00,4'h0,4'h0,2'd0,32'h0,8'h00,1'b0},
    '{88'h660F380CC0,           5'd5, 5'd5, 5'd0, 1'b0,1'b0,1'b0, 8'h00,4'h0,4'h0,2'd0,32'h0,8'h00,1'b0},
    '{88'h660F381FC0,           5'd5, 5'd5, 5'd0, 1'b0,1'b0,1'b0, 8'h00,4'h0,4'h0,2'd0,32'h0,8'h00,1'b0},
    '{88'h660E3800C0,           5'd5, 5'd5, 5'd0, 1'b0,1'b0,1'b0, 8'h00,4'h0,4'h0,2'd0,32'h0,8'h00,1'b0},
    '{88'h0F3900C0,             5'd4, 5'd4, 5'd0, 1'b0,1'b0,1'b0, 8'h00,4'h0,4'h0,2'd0,32'h0,8'h00,1'b0},
    '{88'h660F38008001020304,   5'd9, 5'd8, 5'd0, 1'b0,1'b1,1'b0, 8'h00,4'h0,4'h0,2'd0,32'h0,8'h00,1'b0},
    '{88'h660F3A0FC001,         5'd6, 5'd5, 5'd0, 1'b0,1'b1,1'b0, 8'h00,4'h0,4'h0,2'd0,32'h0,8'h00,1'b0},
    '{88'h0F380000,             5'd4, 5'd4, 5'd4, 1'b1,1'b0,1'b0, 8'h00,4'h0,4'h0,2'd0,32'h0,8'h00,1'b0},
    '{88'h0F380000,             5'd4, 5'd3, 5'd0, 1'b0,1'b1,1'b0, 8'h00,4'h0,4'h0,2'd0,32'h0,8'h00,1'b0}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0;
  logic [8*WINDOW-1:0] in_bytes = '0;
  logic [CW-1:0] in_count = '0;
  logic out_valid, out_handled, out_truncated, out_wide, out_has_imm;
  logic [CW-1:0] out_len;
  logic [7:0] out_opcode, out_imm;
  logic [3:0] out_dst, out_src;
  logic [1:0] out_mode;
  logic [31:0] out_disp;

  int checks = 0;
  int fails = 0;

  always #2.5 clk = ~clk;

  simd_ext_len_decoder #(.WINDOW(WINDOW)) u_dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_bytes(in_bytes),
    .in_count(in_count), .out_valid(out_valid), .out_handled(out_handled),
    .out_truncated(out_truncated), .out_len(out_len), .out_wide(out_wide),
    .out_opcode(out_opcode), .out_dst(out_dst), .out_src(out_src),
    .out_mode(out_mode), .out_disp(out_disp), .out_imm(out_imm),
    .out_has_imm(out_has_imm)
  );

  task automatic chk(input string req, input string what, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [8*WINDOW-1:0] pack_win(input vec_t v);
    logic [8*WINDOW-1:0] w = '0;
    for (int i = 0; i < int'(v.n); i++)
      w[8*i +: 8] = v.seq[8*(int'(v.n)-1-i) +: 8];
    return w;
  endfunction

  task automatic drive(input int k);
    in_valid = 1'b1;
    in_bytes = pack_win(VEC[k]);
    in_count = VEC[k].cnt;
  endtask

  task automatic compare(input int k);
    vec_t v = VEC[k];
    chk("R11", "out_valid", 32'(out_valid), 32'd1);
    chk("R4", "handled", 32'(out_handled), 32'(v.hnd));
    chk("R10", "truncated", 32'(out_truncated), 32'(v.trc));
    chk("R9", "len", 32'(out_len), 32'(v.len));
    chk("R1", "wide", 32'(out_wide), 32'(v.wide));
    chk("R4", "opcode", 32'(out_opcode), 32'(v.op));
    chk("R8", "dst", 32'(out_dst), 32'(v.dst));
    chk("R2", "src", 32'(out_src), 32'(v.src));
    chk("R5", "mode", 32'(out_mode), 32'(v.mode));
    chk("R6", "disp", out_disp, v.disp);
    chk("R7", "imm", 32'(out_imm), 32'(v.imm));
    chk("R7", "has_imm", 32'(out_has_imm), 32'(v.himm));
  endtask

  initial begin
    #(5.0 * 20000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R11: reset state
    chk("R11", "reset out_valid", 32'(out_valid), 32'd0);
    chk("R11", "reset out_len", 32'(out_len), 32'd0);
    chk("R11", "reset out_disp", out_disp, 32'd0);
    rst = 1'b0;

    for (int k = 0; k < NV; k++) begin
      @(negedge clk); drive(k);
      @(negedge clk); in_valid = 1'b0;
      compare(k);
    end

    // R11: outputs hold while idle, strobe drops
    @(negedge clk);
    chk("R11", "idle out_valid", 32'(out_valid), 32'd0);
    chk("R11", "idle hold len", 32'(out_len), 32'(VEC[NV-1].len));
    chk("R11", "idle hold trunc", 32'(out_truncated), 32'(VEC[NV-1].trc));

    // R11: back-to-back windows
    @(negedge clk); drive(13);
    @(negedge clk); drive(9);
    compare(13);
    @(negedge clk); in_valid = 1'b0;
    compare(9);

    // R11: reset beats a strobe
    @(negedge clk); drive(6); rst = 1'b1;
    @(negedge clk); in_valid = 1'b0; rst = 1'b0;
    chk("R11", "reset over strobe valid", 32'(out_valid), 32'd0);
    chk("R11", "reset over strobe len", 32'(out_len), 32'd0);
    chk("R11", "reset over strobe imm", 32'(out_imm), 32'd0);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule